// File: doc/BRIEF.md
# USB-SPI Command Packet Reassembler

This block sits behind a USB bulk OUT endpoint of a USB-to-SPI bridge. Host packets of up to 64 bytes arrive as a byte stream framed by a first-byte and a last-byte marker. The block decodes the 16-bit packet identifier, checks the write and read counts that open a transfer, and gathers the write payload of one SPI transaction from a start packet and any number of continue packets into a write buffer. When the buffered byte count reaches the requested write count it raises a one-cycle request to start the SPI transaction.

Any fault latches a 16-bit status code and raises a one-cycle error request for the response side. The configuration-query and restart-response commands each become a one-cycle request of their own. The SPI engine reads the gathered bytes through a synchronous read port, and it reads the counts of the accepted transfer from the length outputs.

Top module: `spi_cmd_assembler`

## Requirements
- R1: While reset is asserted and after it is released, the start, error, configuration and restart requests are low and the status code is 0x0000.
- R2: Multi-byte fields are little-endian, with the low byte first. A two-byte packet with id 0 raises the configuration request and a packet with id 4 raises the restart request. Neither of them changes the status code.
- R3: A packet of fewer than 2 bytes, a packet whose id is 1, 5, 6 or any value above 6 (for example the bytes 0x00 0x01, which form id 0x0100), a start packet shorter than 6 bytes, and a continue packet shorter than 4 bytes each set the status to 0x0008 and raise the error request.
- R4: A start packet has the layout id(2), write count(2), read count(2), payload. Its counts are checked in a fixed order, and the first check that fails sets the status. Bridge disabled gives 0x0005. Write count above 298 gives 0x0003. Read count 0xFFFF gives 0x0009 when full duplex is not supported, which is the default. Any other read count above 298 gives 0x0004. A start packet that passes all checks sets the status to 0x0000.
- R5: Payload bytes are stored in order at buffer addresses from 0 upward. The start payload begins at packet byte 6 and the continue payload begins at packet byte 4. A buffer address presented on the read port returns its byte one clock later.
- R6: When the stored byte count equals the write count, the start request pulses with status 0x0000. This holds whether the data came in one packet or in several. The write and read length outputs then show the counts that were accepted.
- R7: A continue packet has the layout id 3 (2 bytes), data index (2 bytes), payload. If its data index differs from the number of bytes already stored, the status becomes 0x0006 and the error request pulses.
- R8: A payload byte that would make the stored total exceed the write count sets the status to 0x0007 and raises the error request. That byte and every later byte of the packet are not stored.
- R9: While the status is non-zero, a continue packet stores nothing and raises the error request again with the latched code unchanged.
- R10: A continue packet that arrives when no transfer is open gives status 0x0008. No transfer is open after reset, after a start request, or after an error.
- R11: Each request lasts exactly one clock, and at most one request is high at a time. The request appears in the second clock after the clock that accepts the last byte of the packet.
- R12: A start packet with write count 0 and no payload raises the start request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridgeEn | input | 1 | Bridge enabled; when low, start packets are refused |
| inValid | input | 1 | A packet byte is present on inData |
| inFirst | input | 1 | The present byte is the first byte of a packet |
| inLast | input | 1 | The present byte is the last byte of a packet |
| inData | input | 8 | Packet byte |
| rdAddr | input | 9 | Write-buffer read address |
| rdData | output | 8 | Write-buffer byte, one clock after rdAddr |
| startSpi | output | 1 | One-cycle request to start the SPI transaction |
| errorReq | output | 1 | One-cycle request to send an error response |
| configReq | output | 1 | One-cycle configuration-query request |
| restartReq | output | 1 | One-cycle restart-response request |
| statusCode | output | 16 | Latched status code |
| writeLen | output | 9 | Write count of the accepted transfer |
| readLen | output | 16 | Read count of the accepted transfer (the write count in full duplex) |
| duplexMode | output | 1 | The accepted transfer requested full duplex |

## Verification
A stale write index shows up at the ports in two ways. The next continue packet gets a false 0x0006, or the start request fires early or never fires. Both appear two clocks after that packet's last byte. A per-packet state that leaks into the next packet turns a valid command into 0x0008 or stores a header byte into the buffer. A read-back of the buffer one clock after the address is presented exposes the stored byte. A latched status that is wrongly cleared lets a continue packet after a fault raise the start request instead of repeating the error code.

// File: rtl/spi_asm_pkg.sv
package spi_asm_pkg;

  // status codes reported to the response side
  localparam logic [15:0] ST_OK     = 16'h0000;
  localparam logic [15:0] ST_WRCNT  = 16'h0003;
  localparam logic [15:0] ST_RDCNT  = 16'h0004;
  localparam logic [15:0] ST_OFF    = 16'h0005;
  localparam logic [15:0] ST_INDEX  = 16'h0006;
  localparam logic [15:0] ST_OVER   = 16'h0007;
  localparam logic [15:0] ST_UNEXP  = 16'h0008;
  localparam logic [15:0] ST_NODUP  = 16'h0009;

  // host-to-device packet identifiers
  localparam logic [15:0] ID_CFG     = 16'd0;
  localparam logic [15:0] ID_START   = 16'd2;
  localparam logic [15:0] ID_CONT    = 16'd3;
  localparam logic [15:0] ID_RESTART = 16'd4;

  localparam logic [15:0] DUPLEX_RC = 16'hFFFF;

  typedef enum logic [2:0] {
    K_OTHER,
    K_CFG,
    K_START,
    K_CONT,
    K_RESTART
  } pkt_kind_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic wrByte;
    logic clrIdx;
    logic latchCounts;
  } dp_strobe_t;

  function automatic pkt_kind_t decodeId(input logic [15:0] id);
    case (id)
      ID_CFG:     decodeId = K_CFG;
      ID_START:   decodeId = K_START;
      ID_CONT:    decodeId = K_CONT;
      ID_RESTART: decodeId = K_RESTART;
      default:    decodeId = K_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/spi_asm_dpath.sv
module spi_asm_dpath
  import spi_asm_pkg::*;
#(
  parameter int MAX_XFER = 298,
  parameter int AW = 9,
  parameter int LW = 9,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inFirst,
  input  logic [7:0]       inData,
  input  dp_strobe_t       stb,
  input  logic [AW-1:0]    rdAddr,
  output logic [7:0]       rdData,
  output logic [CNT_W-1:0] byteIdx,
  output logic [15:0]      idNow,
  output logic [15:0]      idxNow,
  output logic [15:0]      wcHeld,
  output logic [15:0]      rcNow,
  output logic [LW-1:0]    writeIdx,
  output logic [LW-1:0]    writeLen,
  output logic [15:0]      readLen,
  output logic             duplexMode
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       hdr0, hdr2, hdr3, hdr4;
  logic [LW-1:0]    wrIdx, wrLen;
  logic [15:0]      rcLat;
  logic [7:0]       mem [MAX_XFER];

  // position of the present byte inside its packet
  assign byteIdx = inFirst ? '0 : byteCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt <= '0;
      hdr0    <= '0;
      hdr2    <= '0;
      hdr3    <= '0;
      hdr4    <= '0;
    end else if (inValid) begin
      if (byteIdx != CNT_MAX) byteCnt <= byteIdx + 1'b1;
      else                    byteCnt <= byteIdx;
      if (byteIdx == CNT_W'(0)) hdr0 <= inData;
      if (byteIdx == CNT_W'(2)) hdr2 <= inData;
      if (byteIdx == CNT_W'(3)) hdr3 <= inData;
      if (byteIdx == CNT_W'(4)) hdr4 <= inData;
    end
  end

  // header fields, each valid in the cycle its high byte arrives
  assign idNow  = {inData, hdr0};
  assign idxNow = {inData, hdr2};
  assign wcHeld = {hdr3, hdr2};
  assign rcNow  = {inData, hdr4};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx <= '0;
      wrLen <= '0;
      rcLat <= '0;
    end else begin
      if (stb.clrIdx)      wrIdx <= '0;
      else if (stb.wrByte) wrIdx <= wrIdx + 1'b1;
      if (stb.latchCounts) begin
        wrLen <= wcHeld[LW-1:0];
        rcLat <= rcNow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte) mem[wrIdx[AW-1:0]] <= inData;
    if (int'(rdAddr) < MAX_XFER) rdData <= mem[rdAddr];
    else                         rdData <= 8'h00;
  end

  assign writeIdx   = wrIdx;
  assign writeLen   = wrLen;
  assign duplexMode = (rcLat == DUPLEX_RC);
  assign readLen    = duplexMode ? 16'(wrLen) : rcLat;

endmodule

// File: rtl/spi_asm_ctrl.sv
module spi_asm_ctrl
  import spi_asm_pkg::*;
#(
  parameter int MAX_XFER = 298,
  parameter int LW = 9,
  parameter int CNT_W = 7,
  parameter bit DUPLEX_OK = 1'b0,
  parameter int START_HDR = 6,
  parameter int CONT_HDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridgeEn,
  input  logic             inValid,
  input  logic             inFirst,
  input  logic             inLast,
  input  logic [CNT_W-1:0] byteIdx,
  input  logic [15:0]      idNow,
  input  logic [15:0]      idxNow,
  input  logic [15:0]      wcHeld,
  input  logic [15:0]      rcNow,
  input  logic [LW-1:0]    writeIdx,
  input  logic [LW-1:0]    writeLen,
  output dp_strobe_t       stb,
  output logic             startSpi,
  output logic             errorReq,
  output logic             configReq,
  output logic             restartReq,
  output logic [15:0]      statusCode
);

  localparam logic [15:0] MAX_CNT = 16'(MAX_XFER);

  pkt_kind_t   kind;
  logic [15:0] pktCode;
  logic        copyOk;
  logic        endPend;
  logic        xferOpen;
  logic [15:0] statusReg;

  logic        startHdr, contHdr, payloadByte, room, overflow;
  logic [15:0] startCode, contCode;

  assign startHdr = inValid && (kind == K_START) && (byteIdx == CNT_W'(START_HDR - 1));
  assign contHdr  = inValid && (kind == K_CONT)  && (byteIdx == CNT_W'(CONT_HDR - 1));

  // ordered checks on the counts of a start packet
  always_comb begin
    if (!bridgeEn)               startCode = ST_OFF;
    else if (wcHeld > MAX_CNT)   startCode = ST_WRCNT;
    else if (rcNow == DUPLEX_RC) startCode = DUPLEX_OK ? ST_OK : ST_NODUP;
    else if (rcNow > MAX_CNT)    startCode = ST_RDCNT;
    else                         startCode = ST_OK;
  end

  // checks on a continue packet once its index is known
  always_comb begin
    if (statusReg != ST_OK)           contCode = statusReg;
    else if (!xferOpen)               contCode = ST_UNEXP;
    else if (idxNow != 16'(writeIdx)) contCode = ST_INDEX;
    else                              contCode = ST_OK;
  end

  assign payloadByte = inValid && copyOk && !inFirst;
  assign room        = writeIdx < writeLen;
  assign overflow    = payloadByte && !room;

  always_comb begin
    stb             = '0;
    stb.wrByte      = payloadByte && room;
    stb.clrIdx      = startHdr && (startCode == ST_OK);
    stb.latchCounts = startHdr && (startCode == ST_OK);
  end

  // per-packet decode state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind    <= K_OTHER;
      pktCode <= ST_UNEXP;
      copyOk  <= 1'b0;
      endPend <= 1'b0;
    end else begin
      endPend <= inValid && inLast;
      if (inValid) begin
        if (byteIdx == CNT_W'(0)) begin
          kind    <= K_OTHER;
          pktCode <= ST_UNEXP;
          copyOk  <= 1'b0;
        end
        if (byteIdx == CNT_W'(1)) kind <= decodeId(idNow);
        if (startHdr) begin
          pktCode <= startCode;
          copyOk  <= (startCode == ST_OK);
        end
        if (contHdr) begin
          pktCode <= contCode;
          copyOk  <= (contCode == ST_OK);
        end
        if (overflow) begin
          pktCode <= ST_OVER;
          copyOk  <= 1'b0;
        end
      end
    end
  end

  // end-of-packet evaluation, one clock after the last byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusReg  <= ST_OK;
      xferOpen   <= 1'b0;
      startSpi   <= 1'b0;
      errorReq   <= 1'b0;
      configReq  <= 1'b0;
      restartReq <= 1'b0;
    end else begin
      startSpi   <= 1'b0;
      errorReq   <= 1'b0;
      configReq  <= 1'b0;
      restartReq <= 1'b0;
      if (endPend) begin
        case (kind)
          K_CFG:     configReq  <= 1'b1;
          K_RESTART: restartReq <= 1'b1;
          K_START, K_CONT: begin
            statusReg <= pktCode;
            if (pktCode != ST_OK) begin
              errorReq <= 1'b1;
              xferOpen <= 1'b0;
            end else if (writeIdx == writeLen) begin
              startSpi <= 1'b1;
              xferOpen <= 1'b0;
            end else begin
              xferOpen <= 1'b1;
            end
          end
          default: begin
            statusReg <= ST_UNEXP;
            errorReq  <= 1'b1;
            xferOpen  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign statusCode = statusReg;

  logic unusedFirst;
  assign unusedFirst = inFirst;

endmodule

// File: rtl/spi_cmd_assembler.sv
module spi_cmd_assembler
  import spi_asm_pkg::*;
#(
  parameter int START_PAY = 58,
  parameter int CONT_PAY = 60,
  parameter int CONT_PKTS = 4,
  parameter bit DUPLEX_OK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridgeEn,
  input  logic inValid,
  input  logic inFirst,
  input  logic inLast,
  input  logic [7:0] inData,
  input  logic [$clog2(START_PAY + CONT_PKTS * CONT_PAY)-1:0] rdAddr,
  output logic [7:0] rdData,
  output logic startSpi,
  output logic errorReq,
  output logic configReq,
  output logic restartReq,
  output logic [15:0] statusCode,
  output logic [$clog2(START_PAY + CONT_PKTS * CONT_PAY + 1)-1:0] writeLen,
  output logic [15:0] readLen,
  output logic duplexMode
);

  localparam int MAX_XFER = START_PAY + CONT_PKTS * CONT_PAY;
  localparam int AW = $clog2(MAX_XFER);
  localparam int LW = $clog2(MAX_XFER + 1);
  localparam int CNT_W = 7;

  dp_strobe_t       stb;
  logic [CNT_W-1:0] byteIdx;
  logic [15:0]      idNow, idxNow, wcHeld, rcNow;
  logic [LW-1:0]    writeIdx;

  spi_asm_ctrl #(
    .MAX_XFER(MAX_XFER), .LW(LW), .CNT_W(CNT_W), .DUPLEX_OK(DUPLEX_OK)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bridgeEn(bridgeEn),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .byteIdx(byteIdx), .idNow(idNow), .idxNow(idxNow),
    .wcHeld(wcHeld), .rcNow(rcNow),
    .writeIdx(writeIdx), .writeLen(writeLen),
    .stb(stb), .startSpi(startSpi), .errorReq(errorReq),
    .configReq(configReq), .restartReq(restartReq),
    .statusCode(statusCode)
  );

  spi_asm_dpath #(
    .MAX_XFER(MAX_XFER), .AW(AW), .LW(LW), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFirst(inFirst),
    .inData(inData), .stb(stb), .rdAddr(rdAddr), .rdData(rdData),
    .byteIdx(byteIdx), .idNow(idNow), .idxNow(idxNow),
    .wcHeld(wcHeld), .rcNow(rcNow), .writeIdx(writeIdx),
    .writeLen(writeLen), .readLen(readLen), .duplexMode(duplexMode)
  );

endmodule

// File: rtl/spi_cmd_assembler_chk.sv
module spi_cmd_assembler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        startSpi,
  input logic        errorReq,
  input logic        configReq,
  input logic        restartReq,
  input logic [15:0] statusCode
);

  // R11
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({startSpi, errorReq, configReq, restartReq}));

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startSpi |=> !startSpi);

  // R6
  start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startSpi |-> (statusCode == 16'h0000));

  // R3
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errorReq |-> (statusCode != 16'h0000));

  // R2
  cfg_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (configReq || restartReq) |-> $stable(statusCode));

endmodule

bind spi_cmd_assembler spi_cmd_assembler_chk chk (
  .clk(clk), .rst_n(rst_n), .startSpi(startSpi), .errorReq(errorReq),
  .configReq(configReq), .restartReq(restartReq), .statusCode(statusCode)
);

// File: tb/spi_cmd_assembler_test.sv
module spi_cmd_assembler_test;

  localparam int CLK_P = 10;
  localparam int NVEC = 9;

  // {enable, expect start, write count, read count, expected status}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 16'd0,   16'd298,   16'h0000},
    {1'b1, 1'b0, 16'd298, 16'd298,   16'h0000},
    {1'b0, 1'b0, 16'd4,   16'd0,     16'h0005},
    {1'b0, 1'b0, 16'd299, 16'd299,   16'h0005},
    {1'b1, 1'b0, 16'd299, 16'd0,     16'h0003},
    {1'b1, 1'b0, 16'd299, 16'hFFFF,  16'h0003},
    {1'b1, 1'b0, 16'd10,  16'hFFFF,  16'h0009},
    {1'b1, 1'b0, 16'd10,  16'd299,   16'h0004},
    {1'b1, 1'b0, 16'd10,  16'd298,   16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridgeEn = 1'b1;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0] inData = 8'h00;
  logic [8:0] rdAddr = '0;
  logic [7:0] rdData;
  logic startSpi, errorReq, configReq, restartReq, duplexMode;
  logic [15:0] statusCode, readLen;
  logic [8:0] writeLen;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] pkt [64];
  logic sStart, sErr, sCfg, sRst;
  logic [15:0] sStat;
  logic [7:0] rb;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_assembler uut (
    .clk(clk), .rst_n(rst_n), .bridgeEn(bridgeEn), .inValid(inValid),
    .inFirst(inFirst), .inLast(inLast), .inData(inData), .rdAddr(rdAddr),
    .rdData(rdData), .startSpi(startSpi), .errorReq(errorReq),
    .configReq(configReq), .restartReq(restartReq), .statusCode(statusCode),
    .writeLen(writeLen), .readLen(readLen), .duplexMode(duplexMode)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setStart(input logic [15:0] wc, input logic [15:0] rc);
    pkt[0] = 8'h02; pkt[1] = 8'h00;
    pkt[2] = wc[7:0]; pkt[3] = wc[15:8];
    pkt[4] = rc[7:0]; pkt[5] = rc[15:8];
  endtask

  task automatic setCont(input logic [15:0] idx);
    pkt[0] = 8'h03; pkt[1] = 8'h00;
    pkt[2] = idx[7:0]; pkt[3] = idx[15:8];
  endtask

  task automatic runPkt(input int len);
    logic early, late;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inFirst = (i == 0); inLast = (i == len - 1); inData = pkt[i];
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    early = startSpi | errorReq | configReq | restartReq;
    @(negedge clk);
    sStart = startSpi; sErr = errorReq; sCfg = configReq; sRst = restartReq;
    sStat = statusCode;
    @(negedge clk);
    late = startSpi | errorReq | configReq | restartReq;
    check(!early && !late, "R11 pulse timing", {early, late}, 0);
  endtask

  task automatic readBuf(input int a);
    @(negedge clk); rdAddr = 9'(a);
    @(negedge clk); rb = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({startSpi, errorReq, configReq, restartReq} == 4'b0 && statusCode == 16'h0,
          "R1 in reset", {startSpi, errorReq, configReq, restartReq, statusCode}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({startSpi, errorReq, configReq, restartReq} == 4'b0 && statusCode == 16'h0,
          "R1 after reset", {startSpi, errorReq, configReq, restartReq, statusCode}, 0);

    // start-packet count checks, walked from the table
    for (int v = 0; v < NVEC; v++) begin
      logic [49:0] e;
      e = VEC[v];
      bridgeEn = e[49];
      setStart(e[47:32], e[31:16]);
      runPkt(6);
      if (e[48]) begin
        check(sStart && !sErr && sStat == 16'h0, "R12 zero write count", {sStart, sErr, sStat}, {2'b10, 16'h0});
      end else begin
        check(sStat == e[15:0], "R4 status", sStat, e[15:0]);
        check(sErr == (e[15:0] != 16'h0) && !sStart, "R4 request", {sStart, sErr}, {1'b0, e[15:0] != 16'h0});
      end
    end
    bridgeEn = 1'b1;

    // single-packet transfer
    setStart(16'd5, 16'd7);
    for (int i = 0; i < 5; i++) pkt[6 + i] = pat(i);
    runPkt(11);
    check(sStart && !sErr, "R6 single packet start", {sStart, sErr}, 2'b10);
    check(writeLen == 9'd5 && readLen == 16'd7, "R6 lengths", {writeLen, readLen}, {9'd5, 16'd7});

    // multi-packet transfer
    setStart(16'd70, 16'd3);
    for (int i = 0; i < 58; i++) pkt[6 + i] = pat(i);
    runPkt(64);
    check(!sStart && !sErr && sStat == 16'h0, "R6 partial no start", {sStart, sErr, sStat}, 0);
    setCont(16'd58);
    for (int i = 0; i < 12; i++) pkt[4 + i] = pat(58 + i);
    runPkt(16);
    check(sStart && !sErr, "R6 multi packet start", {sStart, sErr}, 2'b10);
    check(writeLen == 9'd70 && readLen == 16'd3 && !duplexMode, "R6 multi lengths",
          {writeLen, readLen}, {9'd70, 16'd3});
    readBuf(0);  check(rb == pat(0),  "R5 buf[0]",  rb, pat(0));
    readBuf(57); check(rb == pat(57), "R5 buf[57]", rb, pat(57));
    readBuf(58); check(rb == pat(58), "R5 buf[58]", rb, pat(58));
    readBuf(69); check(rb == pat(69), "R5 buf[69]", rb, pat(69));

    // R10: continue with no open transfer
    setCont(16'd70);
    runPkt(4);
    check(sErr && sStat == 16'h0008, "R10 no open transfer", {sErr, sStat}, {1'b1, 16'h0008});

    // R7: bad data index
    setStart(16'd70, 16'd0);
    for (int i = 0; i < 58; i++) pkt[6 + i] = pat(i);
    runPkt(64);
    setCont(16'd50);
    pkt[4] = 8'hAA; pkt[5] = 8'hAA;
    runPkt(6);
    check(sErr && !sStart && sStat == 16'h0006, "R7 bad index", {sErr, sStat}, {1'b1, 16'h0006});

    // R9: latched error, nothing stored
    setCont(16'd58);
    for (int i = 0; i < 4; i++) pkt[4 + i] = 8'hAA;
    runPkt(8);
    check(sErr && !sStart && sStat == 16'h0006, "R9 latched code", {sErr, sStat}, {1'b1, 16'h0006});
    readBuf(58); check(rb == pat(58), "R9 buf untouched", rb, pat(58));

    // R8: overflow inside a start packet
    setStart(16'd2, 16'd0);
    for (int i = 0; i < 3; i++) pkt[6 + i] = 8'h55;
    runPkt(9);
    check(sErr && !sStart && sStat == 16'h0007, "R8 overflow", {sErr, sStat}, {1'b1, 16'h0007});
    readBuf(1); check(rb == 8'h55, "R8 in-range byte stored", rb, 8'h55);
    readBuf(2); check(rb == pat(2), "R8 excess byte dropped", rb, pat(2));

    // R3: malformed and unknown packets
    pkt[0] = 8'h00;
    runPkt(1);
    check(sErr && sStat == 16'h0008, "R3 one byte", {sErr, sStat}, {1'b1, 16'h0008});
    pkt[0] = 8'h05; pkt[1] = 8'h00;
    runPkt(2);
    check(sErr && sStat == 16'h0008, "R3 id 5", {sErr, sStat}, {1'b1, 16'h0008});
    pkt[0] = 8'h00; pkt[1] = 8'h01;
    runPkt(2);
    check(sErr && !sCfg && sStat == 16'h0008, "R3 id 0x0100", {sErr, sCfg, sStat}, {2'b10, 16'h0008});
    setStart(16'd0, 16'd0);
    runPkt(4);
    check(sErr && !sStart && sStat == 16'h0008, "R3 short start", {sErr, sStat}, {1'b1, 16'h0008});

    // R2: configuration and restart commands
    pkt[0] = 8'h00; pkt[1] = 8'h00;
    runPkt(2);
    check(sCfg && !sErr && sStat == 16'h0008, "R2 config", {sCfg, sErr, sStat}, {2'b10, 16'h0008});
    pkt[0] = 8'h04; pkt[1] = 8'h00;
    runPkt(2);
    check(sRst && !sErr && sStat == 16'h0008, "R2 restart", {sRst, sErr, sStat}, {2'b10, 16'h0008});

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule